// File: doc/BRIEF.md
# Selectable Event Counter Bank

This block keeps a bank of statistics counters for the error and event pulses of a serial link controller. There are 35 event kinds, arranged in five groups. Two of the groups carry one copy of each event per lane. The others carry a single copy for the whole link. Software never sees the counters as a flat array. It writes one control word that names a group, an event and a lane, and that same word carries a small command code to switch the named counter on or off. A second register returns the value of whichever counter the control word currently names.

A counter is cleared only when it goes from off to on. While it is off it keeps its last value, and that value can still be read. An enabled counter adds one on every clock in which its event input is high. It stops at all-ones. Selections that name no counter read as zero, and commands sent to them do nothing. The block is meant to sit behind a simple register port in a link controller's debug space.

Top module: `evcb_top`

## Requirements
- R1: After reset every counter is disabled and the selection is group 0, event 0, lane 0. Reads of both registers then return zero.
- R2: The control register is at byte offset 0x8. Its fields are group in bits [27:24], event in [23:16], lane in [11:8] and command in [4:2]. A read returns group, event and lane as last written. Bit 7 holds the enable state of the selected counter. All other bits, including the command field, read as zero.
- R3: A control write with command 3'b011 enables the counter named by the written selection. If that counter was off, it is also cleared to zero. If it was already on, it keeps counting with no clear. Command 3'b001 disables the named counter. The named counter does not count in the cycle its enable state changes.
- R4: Any other command code changes no enable state and no count. The selection fields of that write are still stored.
- R5: An enabled counter adds one at each clock edge where its event input is high. A disabled counter holds its value, and that value stays readable at offset 0xC.
- R6: A counter at all-ones stays at all-ones. It does not wrap.
- R7: These group/event pairs are valid: group 0 events 0..10, group 1 events 5..10 and 12..13, group 2 events 0..7, group 3 events 0..5, group 4 events 0..1. Per-lane events use bit lane*13+k of `ln_evt_i`, where k is the event number for group 0 and 11+event for group 4. Shared events use bit j of `sh_evt_i`, where j is event-5 for group 1 events below 11, event-6 for group 1 events 12..13, 8+event for group 2 and 16+event for group 3.
- R8: For groups 0 and 4, the lane field chooses which lane's counter is commanded, reported and read. For groups 1 to 3 the lane field has no effect.
- R9: A selection with an invalid group/event pair, or with a per-lane group and a lane at or above LANES, reads data 0 and status 0. A command sent to it changes no counter.
- R10: Offset 0xC is read-only, and writes to it change nothing. Reads of any offset other than 0x8 and 0xC return zero. Read data appears one clock after the read request and shows the state from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Read data, registered |
| ln_evt_i | input | LANES*13 | Per-lane event pulses |
| sh_evt_i | input | 22 | Link-wide event pulses |

## Verification
Each result has a fixed delay after its stimulus. A control write takes effect at the next edge, and an event that is high at an edge is counted at that edge. A read returns the value the state held before the edge that captures the request. The bench drives every input on the falling edge and runs its reference model on the rising edge. The model works out each read result from the state as it stood before that edge, and only then applies the commands and events of that edge. Read data is compared on the following falling edge. The directed checks add fixed expected values at the same sample point, and these do not depend on the model.

// File: rtl/evcb_pkg.sv
package evcb_pkg;

   localparam int LN_SLOTS = 13;
   localparam int SH_SLOTS = 22;

   localparam int GRP_LSB  = 24;
   localparam int EVT_LSB  = 16;
   localparam int LANE_LSB = 8;
   localparam int STAT_BIT = 7;
   localparam int CMD_LSB  = 2;

   localparam logic [2:0] CMD_ON  = 3'b011;
   localparam logic [2:0] CMD_OFF = 3'b001;

   localparam int CTRL_OFF = 8;
   localparam int DATA_OFF = 12;

   typedef struct packed {
      logic       ok;
      logic       per_lane;
      logic [4:0] slot;
   } evcb_map_t;

   // group/event -> slot within its class (per-lane or shared)
   function automatic evcb_map_t evcb_map(input logic [3:0] grp, input logic [7:0] evt);
      evcb_map_t m;
      m = '0;
      case (grp)
         4'd0: if (evt <= 8'd10) begin
            m.ok = 1'b1; m.per_lane = 1'b1; m.slot = evt[4:0];
         end
         4'd4: if (evt <= 8'd1) begin
            m.ok = 1'b1; m.per_lane = 1'b1; m.slot = 5'd11 + evt[4:0];
         end
         4'd1: if (evt >= 8'd5 && evt <= 8'd13 && evt != 8'd11) begin
            m.ok = 1'b1;
            m.slot = (evt < 8'd11) ? evt[4:0] - 5'd5 : evt[4:0] - 5'd6;
         end
         4'd2: if (evt <= 8'd7) begin
            m.ok = 1'b1; m.slot = 5'd8 + evt[4:0];
         end
         4'd3: if (evt <= 8'd5) begin
            m.ok = 1'b1; m.slot = 5'd16 + evt[4:0];
         end
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/evcb_sel_decode.sv
module evcb_sel_decode
   import evcb_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IW    = 7
) (
   input  logic [3:0]    grp,
   input  logic [7:0]    evt,
   input  logic [3:0]    lane,
   output logic          ok,
   output logic [IW-1:0] idx
);

   evcb_map_t m;
   int        flat;

   always_comb begin
      m  = evcb_map(grp, evt);
      ok = m.ok && (!m.per_lane || int'(lane) < LANES);
      if (m.per_lane)
         flat = int'(lane) * LN_SLOTS + int'(m.slot);
      else
         flat = LANES * LN_SLOTS + int'(m.slot);
      idx = IW'(flat);
   end

endmodule

// File: rtl/evcb_cell.sv
module evcb_cell #(
   parameter int CW       = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt,
   input  logic          cmd_on,
   input  logic          cmd_off,
   output logic          en_o,
   output logic [CW-1:0] cnt_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nxt;
   logic          en_q;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (&cnt_q) ? cnt_q : cnt_q + CW'(1);
      end else begin : g_wrap
         assign nxt = cnt_q + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (cmd_on && !en_q) begin
         en_q  <= 1'b1;
         cnt_q <= '0;
      end else if (cmd_off) begin
         en_q  <= 1'b0;
      end else if (en_q && evt) begin
         cnt_q <= nxt;
      end
   end

   assign en_o  = en_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/evcb_top.sv
module evcb_top
   import evcb_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int CW       = 32,
   parameter int AW       = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [31:0]               wr_data,
   input  logic                      rd_en,
   input  logic [AW-1:0]             rd_addr,
   output logic [31:0]               rd_data,
   input  logic [LANES*LN_SLOTS-1:0] ln_evt_i,
   input  logic [SH_SLOTS-1:0]       sh_evt_i
);

   localparam int LN_BITS = LANES * LN_SLOTS;
   localparam int NCNT    = LN_BITS + SH_SLOTS;
   localparam int IW      = $clog2(NCNT);

   generate
      if (LANES < 1 || LANES > 16) begin : g_bad_lanes
         $error("evcb_top: LANES must be 1..16");
      end
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("evcb_top: CW must be 2..32");
      end
      if (AW < 4) begin : g_bad_aw
         $error("evcb_top: AW must cover offset 0xC");
      end
   endgenerate

   logic [3:0]  grp_q;
   logic [7:0]  evt_q;
   logic [3:0]  lane_q;
   logic [31:0] rd_q;

   logic          wr_ctrl;
   logic [2:0]    cmd;
   logic          wr_ok, cur_ok;
   logic [IW-1:0] wr_idx, cur_idx;

   logic [NCNT-1:0]    evt_all;
   logic [NCNT-1:0]    en_vec;
   logic [NCNT*CW-1:0] cnt_flat;
   logic [CW-1:0]      sel_cnt;
   logic               sel_en;
   logic [31:0]        ctrl_rb;
   logic               unused_wr_bits;

   assign wr_ctrl = wr_en && (wr_addr == AW'(CTRL_OFF));
   assign cmd     = wr_data[CMD_LSB +: 3];
   assign evt_all = {sh_evt_i, ln_evt_i};
   assign unused_wr_bits = ^{wr_data[31:28], wr_data[15:12], wr_data[7:5], wr_data[1:0]};

   // decode of the selection carried by a control write
   evcb_sel_decode #(.LANES(LANES), .IW(IW)) u_wr_dec (
      .grp  (wr_data[GRP_LSB +: 4]),
      .evt  (wr_data[EVT_LSB +: 8]),
      .lane (wr_data[LANE_LSB +: 4]),
      .ok   (wr_ok),
      .idx  (wr_idx)
   );

   // decode of the stored selection for status and data reads
   evcb_sel_decode #(.LANES(LANES), .IW(IW)) u_cur_dec (
      .grp  (grp_q),
      .evt  (evt_q),
      .lane (lane_q),
      .ok   (cur_ok),
      .idx  (cur_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q  <= '0;
         evt_q  <= '0;
         lane_q <= '0;
      end else if (wr_ctrl) begin
         grp_q  <= wr_data[GRP_LSB +: 4];
         evt_q  <= wr_data[EVT_LSB +: 8];
         lane_q <= wr_data[LANE_LSB +: 4];
      end
   end

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_cnt
         logic hit;
         assign hit = wr_ctrl && wr_ok && (wr_idx == IW'(i));
         evcb_cell #(.CW(CW), .SATURATE(SATURATE)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_all[i]),
            .cmd_on  (hit && cmd == CMD_ON),
            .cmd_off (hit && cmd == CMD_OFF),
            .en_o    (en_vec[i]),
            .cnt_o   (cnt_flat[i*CW +: CW])
         );
      end
   endgenerate

   always_comb begin
      sel_cnt = '0;
      sel_en  = 1'b0;
      for (int i = 0; i < NCNT; i++) begin
         if (cur_idx == IW'(i)) begin
            sel_cnt = cnt_flat[i*CW +: CW];
            sel_en  = en_vec[i];
         end
      end
   end

   always_comb begin
      ctrl_rb                   = '0;
      ctrl_rb[GRP_LSB +: 4]     = grp_q;
      ctrl_rb[EVT_LSB +: 8]     = evt_q;
      ctrl_rb[LANE_LSB +: 4]    = lane_q;
      ctrl_rb[STAT_BIT]         = cur_ok && sel_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         if (rd_addr == AW'(CTRL_OFF))
            rd_q <= ctrl_rb;
         else if (rd_addr == AW'(DATA_OFF))
            rd_q <= cur_ok ? 32'(sel_cnt) : 32'd0;
         else
            rd_q <= '0;
      end
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/evcb_chk.sv
module evcb_chk #(
   parameter int LANES    = 4,
   parameter int CW       = 32,
   parameter int AW       = 4,
   parameter int NCNT     = 74,
   parameter bit SATURATE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [AW-1:0]      wr_addr,
   input logic [31:0]        wr_data,
   input logic               rd_en,
   input logic [AW-1:0]      rd_addr,
   input logic [31:0]        rd_data,
   input logic [NCNT-1:0]    en_vec,
   input logic [NCNT*CW-1:0] cnt_flat
);

   logic ctrl_wr;
   logic on_wr;
   logic unused_chk;

   assign ctrl_wr    = wr_en && (wr_addr == AW'(8));
   assign on_wr      = ctrl_wr && (wr_data[4:2] == 3'b011);
   assign unused_chk = ^{wr_data[31:5], wr_data[1:0], LANES[0]};

   // R2
   ctrl_rb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == AW'(8)) |=> (rd_data[6:0] == 7'd0 && rd_data[31:28] == 4'd0));

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr != AW'(8) && rd_addr != AW'(12)) |=> (rd_data == 32'd0));

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_c
         // R3
         en_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[i] && !on_wr) |=> !en_vec[i]);
         // R3
         clear_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_vec[i]) |-> (cnt_flat[i*CW +: CW] == '0));
         // R5
         hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[i] && !ctrl_wr) |=> $stable(cnt_flat[i*CW +: CW]));
         if (SATURATE) begin : g_s
            // R6
            no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (&cnt_flat[i*CW +: CW] && !ctrl_wr) |=> (&cnt_flat[i*CW +: CW]));
         end
      end
   endgenerate

endmodule

bind evcb_top evcb_chk #(
   .LANES(LANES), .CW(CW), .AW(AW), .NCNT(NCNT), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
   .en_vec(en_vec), .cnt_flat(cnt_flat)
);

// File: tb/sim_evcb_top.sv
module sim_evcb_top;

   localparam int TCLK  = 10;
   localparam int LANES = 4;
   localparam int CW    = 8;
   localparam int AW    = 4;
   localparam int LNB   = LANES * 13;
   localparam int NC    = LNB + 22;
   localparam int CMAX  = (1 << CW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     rd_addr = '0;
   logic [31:0]       rd_data;
   logic [LNB-1:0]    ln_evt = '0;
   logic [21:0]       sh_evt = '0;

   always #(TCLK/2) clk = ~clk;

   evcb_top #(.LANES(LANES), .CW(CW), .AW(AW), .SATURATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .ln_evt_i(ln_evt), .sh_evt_i(sh_evt)
   );

   int    total = 0;
   int    bad = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // ---------------- reference model ----------------
   int tab_cls [5][16];
   int tab_slot[5][16];
   bit m_en [NC];
   int m_cnt[NC];
   int m_g = 0, m_e = 0, m_l = 0;
   bit pend = 1'b0;
   logic [31:0] exp_rd = '0;

   function automatic bit member(int g, int e);
      case (g)
         0: return e <= 10;
         1: return e >= 5 && e <= 13 && e != 11;
         2: return e <= 7;
         3: return e <= 5;
         4: return e <= 1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      int nl = 0;
      int ns = 0;
      for (int g = 0; g < 5; g++)
         for (int e = 0; e < 16; e++) begin
            tab_cls[g][e] = 0;
            tab_slot[g][e] = 0;
            if (member(g, e)) begin
               if (g == 0 || g == 4) begin tab_cls[g][e] = 1; tab_slot[g][e] = nl; nl++; end
               else begin tab_cls[g][e] = 2; tab_slot[g][e] = ns; ns++; end
            end
         end
   end

   function automatic int idx_of(int g, int e, int l);
      if (g > 4 || e > 15) return -1;
      if (tab_cls[g][e] == 0) return -1;
      if (tab_cls[g][e] == 1) return (l >= LANES) ? -1 : l * 13 + tab_slot[g][e];
      return LNB + tab_slot[g][e];
   endfunction

   function automatic bit ev_bit(int i);
      if (i < LNB) return ln_evt[i];
      return sh_evt[i - LNB];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NC; i++) begin m_en[i] = 1'b0; m_cnt[i] = 0; end
         m_g = 0; m_e = 0; m_l = 0; pend = 1'b0; exp_rd = '0;
      end else begin
         int ci, wi, code;
         bit wc;
         ci = idx_of(m_g, m_e, m_l);
         if (rd_en) begin
            pend = 1'b1;
            if (rd_addr == 4'd8) begin
               exp_rd = (m_g << 24) | (m_e << 16) | (m_l << 8);
               if (ci >= 0 && m_en[ci]) exp_rd[7] = 1'b1;
            end else if (rd_addr == 4'd12) begin
               exp_rd = (ci >= 0) ? 32'(m_cnt[ci]) : 32'd0;
            end else exp_rd = 32'd0;
         end else pend = 1'b0;
         wc   = wr_en && wr_addr == 4'd8;
         wi   = wc ? idx_of(int'(wr_data[27:24]), int'(wr_data[23:16]), int'(wr_data[11:8])) : -1;
         code = int'(wr_data[4:2]);
         for (int i = 0; i < NC; i++) begin
            if (i == wi && code == 3 && !m_en[i]) begin m_en[i] = 1'b1; m_cnt[i] = 0; end
            else if (i == wi && code == 1) m_en[i] = 1'b0;
            else if (m_en[i] && ev_bit(i) && m_cnt[i] < CMAX) m_cnt[i]++;
         end
         if (wc) begin
            m_g = int'(wr_data[27:24]); m_e = int'(wr_data[23:16]); m_l = int'(wr_data[11:8]);
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && pend && !done) check(tag, rd_data, exp_rd);

   // ---------------- stimulus helpers ----------------
   task automatic wr_ctrl(int g, int e, int l, int code);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd8;
      wr_data = 32'((g << 24) | (e << 16) | (l << 8) | (code << 2));
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_expect(int a, logic [31:0] exp, string req);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      check(req, rd_data, exp);
   endtask

   task automatic rd_only(int a);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_ln(int b, int n);
      @(negedge clk);
      ln_evt[b] = 1'b1;
      repeat (n) @(negedge clk);
      ln_evt[b] = 1'b0;
   endtask

   task automatic pulse_sh(int b, int n);
      @(negedge clk);
      sh_evt[b] = 1'b1;
      repeat (n) @(negedge clk);
      sh_evt[b] = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset rd_data", rd_data, 32'd0);
      rst_n = 1'b1;
      tag = "R1";
      rd_expect(8, 32'h0000_0000, "R1 ctrl after reset");
      rd_expect(12, 32'h0000_0000, "R1 data after reset");

      tag = "R2";
      wr_ctrl(0, 3, 2, 3);
      rd_expect(8, 32'h0003_0280, "R2 ctrl readback");
      tag = "R5";
      pulse_ln(2*13+3, 5);
      rd_expect(12, 32'd5, "R5 count lane2 g0e3");
      tag = "R8";
      pulse_ln(1*13+3, 3);
      wr_ctrl(0, 3, 1, 0);
      rd_expect(12, 32'd0, "R8 other lane not counted");
      rd_expect(8, 32'h0003_0100, "R8 other lane status off");

      tag = "R3";
      wr_ctrl(0, 3, 2, 1);
      pulse_ln(2*13+3, 4);
      rd_expect(12, 32'd5, "R5 disabled counter holds");
      wr_ctrl(0, 3, 2, 3);
      rd_expect(12, 32'd0, "R3 clear on re-enable");
      pulse_ln(2*13+3, 2);
      wr_ctrl(0, 3, 2, 3);
      rd_expect(12, 32'd2, "R3 on while on keeps count");

      tag = "R4";
      wr_ctrl(0, 3, 2, 2);
      rd_expect(8, 32'h0003_0280, "R4 code 010 no change");
      wr_ctrl(2, 5, 3, 0);
      rd_expect(8, 32'h0205_0300, "R4 code 000 stores selection");

      tag = "R8";
      wr_ctrl(2, 5, 3, 3);
      wr_ctrl(2, 5, 0, 0);
      rd_expect(8, 32'h0205_0080, "R8 shared ignores lane");
      pulse_sh(13, 3);
      rd_expect(12, 32'd3, "R7 shared bit 13 is g2e5");

      tag = "R7";
      for (int g = 0; g < 5; g++)
         for (int e = 0; e < 16; e++)
            for (int l = 0; l < LANES; l++)
               if (member(g, e)) wr_ctrl(g, e, l, 3);
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         ln_evt = LNB'({$urandom, $urandom});
         sh_evt = 22'($urandom);
      end
      @(negedge clk);
      ln_evt = '0; sh_evt = '0;
      for (int g = 0; g < 6; g++)
         for (int e = 0; e < 16; e++)
            for (int l = 0; l < LANES; l++) begin
               wr_ctrl(g, e, l, 0);
               rd_only(12);
               rd_only(8);
            end

      tag = "R9";
      wr_ctrl(1, 11, 0, 3);
      rd_expect(8, 32'h010B_0000, "R9 g1e11 status");
      rd_expect(12, 32'd0, "R9 g1e11 data");
      wr_ctrl(5, 0, 0, 3);
      rd_expect(12, 32'd0, "R9 group 5 data");
      wr_ctrl(0, 0, 5, 3);
      rd_expect(8, 32'h0000_0500, "R9 lane beyond range status");
      rd_expect(12, 32'd0, "R9 lane beyond range data");

      tag = "R10";
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd12; wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_en = 1'b0;
      rd_expect(8, 32'h0000_0500, "R10 data offset write ignored");
      rd_expect(0, 32'd0, "R10 offset 0 reads zero");
      rd_expect(4, 32'd0, "R10 offset 4 reads zero");

      tag = "R6";
      wr_ctrl(3, 2, 0, 1);
      wr_ctrl(3, 2, 0, 3);
      rd_expect(12, 32'd0, "R3 clear before saturation");
      pulse_sh(18, CMAX + 40);
      rd_expect(12, 32'(CMAX), "R6 saturates at all-ones");
      pulse_sh(18, 5);
      rd_expect(12, 32'(CMAX), "R6 stays at all-ones");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule